// File: doc/BRIEF.md
# Sixteen-Bit Register-Pair Add/Subtract Flag Unit

This block performs the wide arithmetic of an 8-bit processor's register pairs: a plain add, an add that includes the carry, and a subtract that includes the borrow. It takes an accumulator operand, a source operand, a carry input and the current flag byte. It returns the 16-bit result and a rebuilt flag byte. The flag behaviour differs from the byte-wide ALU. Half-carry is taken across bit 12. The plain add leaves sign, zero and parity/overflow as they were. The two bits with no documented meaning copy bits 5 and 3 of the result's high byte.

A request is made by raising `start` for one cycle with the operands and operation. The unit registers the result and flags on that edge and raises `valid` during the following cycle. A tiny controller has two states. `ST_IDLE` moves to `ST_VALID` on an accepted request (transition ACCEPT). `ST_VALID` stays in `ST_VALID` on another accepted request (transition CHAIN). It returns to `ST_IDLE` otherwise (transition DRAIN). The outputs hold their last values between requests.

Top module: `alu16_flag_unit`

## Requirements
- R1: After reset, `valid` is 0, `result` is 0x0000 and `flags_out` is 0x00.
- R2: `op` encodes 0=ADD, 1=ADC, 2=SBC and 3=reserved. A request with `start`=1 and `op`≠3 makes `valid` 1 in exactly the next cycle. A reserved request, or no request, makes `valid` 0 in the next cycle, and `result` and `flags_out` keep their previous values.
- R3: ADD gives `result` = (a + b) mod 2^16. Carry (flag bit 0) is set when the unsigned sum exceeds 0xFFFF.
- R4: ADD copies sign (bit 7), zero (bit 6) and parity/overflow (bit 2) from `flags_in` and clears subtract (bit 1).
- R5: For all three operations, half-carry (bit 4) equals bit 12 of (a XOR b XOR result).
- R6: For all three operations, flag bit 5 equals result bit 13 and flag bit 3 equals result bit 11.
- R7: ADC gives `result` = (a + b + cin) mod 2^16. Carry is set when the sum exceeds 0xFFFF. Sign is result bit 15, zero is set when the result is 0, and subtract is cleared.
- R8: ADC sets overflow (bit 2) when a and b share a sign and the result sign differs from it.
- R9: SBC gives `result` = (a − b − cin) mod 2^16. Carry is set on a borrow (a < b + cin), subtract is set, sign is result bit 15, and zero is set when the result is 0.
- R10: SBC sets overflow when a and b differ in sign and the result sign differs from a.
- R11: ADD ignores `cin`: the result is a + b even when `cin` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe |
| op | input | 2 | Operation: 0 ADD, 1 ADC, 2 SBC, 3 reserved |
| a | input | 16 | Accumulator operand |
| b | input | 16 | Source operand |
| cin | input | 1 | Incoming carry |
| flags_in | input | 8 | Current flag byte |
| result | output | 16 | Registered 16-bit result |
| flags_out | output | 8 | Registered new flag byte |
| valid | output | 1 | High in the cycle after an accepted request |

## Verification
The bench builds the unit at its default width of 16. At that width the half-carry tap at bit 12, the sign at bit 15 and the copied bits 13 and 11 sit exactly where the flag byte expects them. Directed operands cover each flag edge: the 0xFFFF wrap, the carry out of the low 12 bits, a signed overflow in both directions, a zero result with carry, and a borrow from zero. Several hundred random requests follow, with idle and reserved cycles mixed in, so that the hold behaviour and back-to-back chaining are also exercised.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_ADC  = 2'd1,
        OP_SBC  = 2'd2,
        OP_RSVD = 2'd3
    } arith_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_VALID = 1'b1
    } out_state_e;

    localparam int FB_S  = 7;
    localparam int FB_Z  = 6;
    localparam int FB_X5 = 5;
    localparam int FB_H  = 4;
    localparam int FB_X3 = 3;
    localparam int FB_PV = 2;
    localparam int FB_N  = 1;
    localparam int FB_C  = 0;

    localparam logic [7:0] KEEP_MASK = (8'd1 << FB_S) | (8'd1 << FB_Z) | (8'd1 << FB_PV);

endpackage

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  arith_op_e          op,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    input  logic               cin,
    output logic [WIDTH:0]     wide
);
    localparam int EXT = WIDTH + 1;

    logic [EXT-1:0] a_x;
    logic [EXT-1:0] b_x;
    logic [EXT-1:0] c_x;

    always_comb begin
        a_x = {1'b0, a};
        b_x = {1'b0, b};
        c_x = {{WIDTH{1'b0}}, cin};
        unique case (op)
            OP_ADD:  wide = a_x + b_x;
            OP_ADC:  wide = a_x + b_x + c_x;
            OP_SBC:  wide = a_x - b_x - c_x;
            default: wide = a_x + b_x;
        endcase
    end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  arith_op_e          op,
    input  logic [WIDTH-1:0]   a,
    input  logic [WIDTH-1:0]   b,
    input  logic [WIDTH:0]     wide,
    input  logic [7:0]         flags_in,
    output logic [7:0]         flags
);
    localparam int MSB    = WIDTH - 1;
    localparam int HALF   = WIDTH - 4;
    localparam int COPY5  = WIDTH - 3;
    localparam int COPY3  = WIDTH - 5;

    logic [WIDTH-1:0] r;
    logic [WIDTH-1:0] mix;
    logic [7:0]       common;

    always_comb begin
        r   = wide[WIDTH-1:0];
        mix = a ^ b ^ r;
        common = 8'h00;
        common[FB_H]  = mix[HALF];
        common[FB_X5] = r[COPY5];
        common[FB_X3] = r[COPY3];
        common[FB_C]  = wide[WIDTH];

        unique case (op)
            OP_ADD: begin
                flags = (flags_in & KEEP_MASK) | common;
            end
            OP_ADC: begin
                flags = common;
                flags[FB_S]  = r[MSB];
                flags[FB_Z]  = (r == '0);
                flags[FB_PV] = ~(a[MSB] ^ b[MSB]) & (a[MSB] ^ r[MSB]);
            end
            OP_SBC: begin
                flags = common;
                flags[FB_N]  = 1'b1;
                flags[FB_S]  = r[MSB];
                flags[FB_Z]  = (r == '0);
                flags[FB_PV] = (a[MSB] ^ b[MSB]) & (a[MSB] ^ r[MSB]);
            end
            default: begin
                flags = (flags_in & KEEP_MASK) | common;
            end
        endcase
    end
endmodule

// File: rtl/alu16_flag_unit.sv
module alu16_flag_unit
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        op,
    input  logic [WIDTH-1:0]  a,
    input  logic [WIDTH-1:0]  b,
    input  logic              cin,
    input  logic [7:0]        flags_in,
    output logic [WIDTH-1:0]  result,
    output logic [7:0]        flags_out,
    output logic              valid
);
    arith_op_e   op_e;
    logic        accept;
    logic [WIDTH:0] wide;
    logic [7:0]  flags_new;
    out_state_e  state_q;
    out_state_e  state_d;

    assign op_e   = arith_op_e'(op);
    assign accept = start && (op_e != OP_RSVD);

    alu16_core #(.WIDTH(WIDTH)) u_core (
        .op   (op_e),
        .a    (a),
        .b    (b),
        .cin  (cin),
        .wide (wide)
    );

    alu16_flags #(.WIDTH(WIDTH)) u_flags (
        .op       (op_e),
        .a        (a),
        .b        (b),
        .wide     (wide),
        .flags_in (flags_in),
        .flags    (flags_new)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_VALID;
            ST_VALID: state_d = accept ? ST_VALID : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            flags_out <= 8'h00;
        end else if (accept) begin
            result    <= wide[WIDTH-1:0];
            flags_out <= flags_new;
        end
    end

    assign valid = (state_q == ST_VALID);
endmodule

// File: rtl/alu16_flag_unit_chk.sv
module alu16_flag_unit_chk
    import alu16_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        op,
    input logic [7:0]        flags_in,
    input logic [WIDTH-1:0]  result,
    input logic [7:0]        flags_out,
    input logic              valid
);
    localparam int COPY5 = WIDTH - 3;
    localparam int COPY3 = WIDTH - 5;

    p_valid_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start && (op != 2'd3)) |-> valid);

    p_no_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start && (op != 2'd3)) |-> !valid);

    p_hold_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start && (op != 2'd3)) |-> ($stable(result) && $stable(flags_out)));

    p_add_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(op) == 2'd0)
            |-> ((flags_out & KEEP_MASK) == ($past(flags_in) & KEEP_MASK)) && !flags_out[FB_N]);

    p_sbc_sets_n_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(op) == 2'd2) |-> flags_out[FB_N]);

    p_adc_clears_n_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && $past(op) == 2'd1) |-> !flags_out[FB_N]);

    p_copy_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (flags_out[FB_X5] == result[COPY5]) && (flags_out[FB_X3] == result[COPY3]));
endmodule

bind alu16_flag_unit alu16_flag_unit_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (op),
    .flags_in  (flags_in),
    .result    (result),
    .flags_out (flags_out),
    .valid     (valid)
);

// File: tb/sim_alu16_flag_unit.sv
module sim_alu16_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op = 2'd0;
    logic [15:0] a = '0;
    logic [15:0] b = '0;
    logic        cin = 1'b0;
    logic [7:0]  flags_in = '0;
    logic [15:0] result;
    logic [7:0]  flags_out;
    logic        valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [15:0] exp_res = '0;
    logic [7:0]  exp_flg = '0;

    always #5 clk = ~clk;

    alu16_flag_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
        .cin(cin), .flags_in(flags_in), .result(result),
        .flags_out(flags_out), .valid(valid)
    );

    task automatic chk(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference: returns {flags, result}
    function automatic logic [23:0] model(input int o, input int x, input int y, input int c, input int f);
        int w, r, fl;
        if (o == 0) begin
            w = x + y;
            fl = f & 32'hC4;
            if (w > 32'hFFFF) fl = fl | 1;
        end else if (o == 1) begin
            w = x + y + c;
            fl = 0;
            if (w > 32'hFFFF) fl = fl | 1;
        end else begin
            w = x - y - c;
            fl = 2;
            if (w < 0) fl = fl | 1;
        end
        r = w & 32'hFFFF;
        if (((x ^ y ^ r) >> 12) & 1) fl = fl | 32'h10;
        if ((r >> 13) & 1) fl = fl | 32'h20;
        if ((r >> 11) & 1) fl = fl | 32'h08;
        if (o != 0) begin
            if (r & 32'h8000) fl = fl | 32'h80;
            if (r == 0) fl = fl | 32'h40;
        end
        if (o == 1 && ((x ^ y ^ 32'h8000) & (x ^ r) & 32'h8000) != 0) fl = fl | 4;
        if (o == 2 && ((x ^ y) & (x ^ r) & 32'h8000) != 0) fl = fl | 4;
        return {fl[7:0], r[15:0]};
    endfunction

    task automatic step(input logic st, input logic [1:0] o, input logic [15:0] x,
                        input logic [15:0] y, input logic c, input logic [7:0] f);
        logic acc;
        logic [23:0] m;
        string tr, tsz, tv;
        @(negedge clk);
        start = st; op = o; a = x; b = y; cin = c; flags_in = f;
        acc = st && (o != 2'd3);
        if (acc) begin
            m = model(int'(o), int'(x), int'(y), int'(c), int'(f));
            exp_res = m[15:0];
            exp_flg = m[23:16];
        end
        @(posedge clk);
        #1;
        start = 1'b0;
        chk(valid == acc, "R2 valid", {23'd0, valid}, {23'd0, acc});
        if (acc) begin
            tr  = (o == 0) ? "R3" : (o == 1) ? "R7" : "R9";
            tsz = (o == 0) ? "R4" : tr;
            tv  = (o == 0) ? "R4" : (o == 1) ? "R8" : "R10";
            chk(result == exp_res, {tr, " result"}, {8'd0, result}, {8'd0, exp_res});
            chk(flags_out[0] == exp_flg[0], {tr, " carry"}, {23'd0, flags_out[0]}, {23'd0, exp_flg[0]});
            chk(flags_out[4] == exp_flg[4], "R5 half", {23'd0, flags_out[4]}, {23'd0, exp_flg[4]});
            chk({flags_out[5], flags_out[3]} == {exp_flg[5], exp_flg[3]}, "R6 copy",
                {16'd0, flags_out}, {16'd0, exp_flg});
            chk({flags_out[7:6], flags_out[1]} == {exp_flg[7:6], exp_flg[1]}, {tsz, " S/Z/N"},
                {16'd0, flags_out}, {16'd0, exp_flg});
            chk(flags_out[2] == exp_flg[2], {tv, " overflow"}, {23'd0, flags_out[2]}, {23'd0, exp_flg[2]});
        end else begin
            chk({flags_out, result} == {exp_flg, exp_res}, "R2 hold",
                {flags_out, result}, {exp_flg, exp_res});
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk({valid, result, flags_out} == 25'd0, "R1 reset", {valid, result, flags_out[6:0]}, 24'd0);
        @(negedge clk);
        rst_n = 1'b1;

        step(1, 2'd0, 16'hFFFF, 16'h0001, 0, 8'h00);   // R3 wrap with carry
        step(1, 2'd0, 16'h0FFF, 16'h0001, 0, 8'hFF);   // R4 keep, R5 half
        step(1, 2'd0, 16'h1234, 16'h0000, 1, 8'h00);   // R11 cin ignored
        chk(result == 16'h1234, "R11 cin ignored", {8'd0, result}, 24'h001234);
        step(1, 2'd1, 16'h7FFF, 16'h0000, 1, 8'h00);   // R8 positive overflow
        step(1, 2'd1, 16'h8000, 16'h8000, 0, 8'h00);   // R8 negative overflow, zero
        step(1, 2'd1, 16'hFFFF, 16'h0000, 1, 8'h00);   // R7 zero with carry
        step(1, 2'd2, 16'h0000, 16'h0001, 0, 8'h00);   // R9 borrow
        step(1, 2'd2, 16'h8000, 16'h0000, 1, 8'h00);   // R10 overflow
        step(1, 2'd2, 16'h0005, 16'h0005, 0, 8'hFF);   // R9 zero
        step(1, 2'd2, 16'h2800, 16'h0000, 0, 8'h00);   // R6 copy bits
        step(1, 2'd3, 16'h1111, 16'h2222, 1, 8'hFF);   // R2 reserved op
        step(0, 2'd1, 16'h1111, 16'h2222, 1, 8'hFF);   // R2 idle hold
        step(0, 2'd0, 16'h0000, 16'h0000, 0, 8'h00);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            step((rv[3:0] != 4'd0), rv[5:4], 16'($urandom), 16'($urandom),
                 rv[6], 8'($urandom));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule